// File: doc/BRIEF.md
# Text Table-Record Parser

This block sits behind a serial receiver and turns a stream of ASCII bytes into write operations for a two-channel profile memory. A short selector line picks the channel and the memory address, and the next line carries one profile point as hexadecimal text. That point holds a frequency word, a phase word, an amplitude word and a dwell count. When a point has been read in full and is well formed, the parser raises a one-cycle write strobe. The strobe comes with the channel, the address and the decoded fields, and the unused upper bits of phase and amplitude are removed.

Bytes arrive one per cycle, marked by a valid input. A selector line is `t` (or `T`), the channel digit, one space, four hex digits and then a line end. A point line is eight hex digits, a comma, four hex digits, a comma, four hex digits, a comma, two hex digits and then a line end. A line end is either CR or LF. Each selector arms exactly one point line. A malformed line produces a one-cycle syntax flag, the line is dropped, and the rest of it up to the line end is ignored. For each point, the channel-1 line must use the same address and dwell as the channel-0 line written just before it. If they differ, a pairing flag is raised together with the channel-1 write.

Top module: `prof_rec_parser`

## Requirements
- R1: After reset, wr_en, syn_err and pair_err are low, every field output is zero and no point line is armed.
- R2: A selector line is `t` or `T`, then `0` or `1`, then a space, then four hex digits, then CR or LF. It sets the channel and the 16-bit address (first digit most significant) for the next point line. Any other channel character gives syn_err.
- R3: A point line accepted after a selector gives wr_en high for exactly one cycle, the cycle after its line-end byte is taken. In that cycle wr_chan and wr_addr come from the selector, and the four fields are read first digit most significant. The field outputs hold their values until the next write.
- R4: wr_phase is the low 14 bits of the 16-bit phase field and wr_amp is the low 10 bits of the 16-bit amplitude field. The dropped upper bits have no effect.
- R5: The hex digits a-f and A-F are equal in value, and `t`/`T` are equal, in both line types.
- R6: Each of the three comma positions must hold `,`. Any other byte there gives syn_err and no write.
- R7: A point line with too few characters (line end too early) or too many (no line end after the dwell digits) gives syn_err and no write.
- R8: A non-hex byte in a digit position gives syn_err and no write. wr_en and syn_err are never high in the same cycle.
- R9: A point line with no armed selector (after reset, after a point has been used, or after an error) gives syn_err and no write.
- R10: A channel-1 write whose address or dwell differs from the channel-0 write just before it raises pair_err in the same cycle as its wr_en. The write still takes place. pair_err is never high without a channel-1 write.
- R11: Bytes with in_valid low are ignored, even in the middle of a line. Empty lines (CR, LF or CR LF) are ignored.
- R12: syn_err is one cycle wide and comes in the cycle after the offending byte. One bad line raises it exactly once, because the bytes after the error up to the line end are skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte holds a received character |
| in_byte | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle write strobe for the profile memory |
| wr_chan | output | 1 | Channel of the write |
| wr_addr | output | 16 | Memory address of the write |
| wr_freq | output | 32 | Frequency word |
| wr_phase | output | 14 | Phase word, active bits only |
| wr_amp | output | 10 | Amplitude word, active bits only |
| wr_dwell | output | 8 | Dwell count |
| syn_err | output | 1 | Syntax error pulse |
| pair_err | output | 1 | Channel pairing mismatch pulse |

## Verification
A wrong position counter shows at the line end as a missing write or a false syn_err on a well-formed line. A field in the wrong place shows as a swapped or shifted nibble on the field outputs in the cycle after the line end. An armed flag left set or cleared by mistake shows when the next point line is accepted or rejected, so the bench sends point lines with no selector and second point lines after a single selector. Stale pairing state shows only on the following channel-1 write, so the pairs in the table put mismatches in the address and in the dwell, each on its own.

// File: rtl/prof_rec_parser.sv
`timescale 1ns/1ps
module prof_rec_parser #(
  parameter int PH_W  = 14,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             wr_en,
  output logic             wr_chan,
  output logic [15:0]      wr_addr,
  output logic [31:0]      wr_freq,
  output logic [PH_W-1:0]  wr_phase,
  output logic [AMP_W-1:0] wr_amp,
  output logic [7:0]       wr_dwell,
  output logic             syn_err,
  output logic             pair_err
);
  localparam int CMD_END = 7;
  localparam int REC_END = 21;
  localparam int NIBS    = 18;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_REC, S_SKIP} st_t;

  st_t             st;
  logic [4:0]      pos;
  logic [4*NIBS-1:0] sh;
  logic            armed, sel_q, ch_q, have0;
  logic [15:0]     addr_q, a0;
  logic [7:0]      d0;

  logic       hv, is_term, is_t;
  logic [3:0] nib;

  always_comb begin
    hv  = 1'b1;
    nib = 4'd0;
    if (in_byte >= "0" && in_byte <= "9")      nib = 4'(in_byte - "0");
    else if (in_byte >= "a" && in_byte <= "f") nib = 4'(in_byte - "a" + 8'd10);
    else if (in_byte >= "A" && in_byte <= "F") nib = 4'(in_byte - "A" + 8'd10);
    else hv = 1'b0;
  end

  assign is_term = (in_byte == 8'h0d) || (in_byte == 8'h0a);
  assign is_t    = (in_byte == "t") || (in_byte == "T");

  logic in_cmd, exp_chan, exp_sp, exp_comma, exp_term, exp_hex, good;
  assign in_cmd    = (st == S_CMD);
  assign exp_chan  = in_cmd && pos == 5'd1;
  assign exp_sp    = in_cmd && pos == 5'd2;
  assign exp_term  = in_cmd ? (pos == 5'(CMD_END)) : (pos == 5'(REC_END));
  assign exp_comma = !in_cmd && (pos == 5'd8 || pos == 5'd13 || pos == 5'd18);
  assign exp_hex   = !exp_chan && !exp_sp && !exp_term && !exp_comma;
  assign good = (exp_term && is_term) || (exp_hex && hv) ||
                (exp_comma && in_byte == ",") || (exp_sp && in_byte == " ") ||
                (exp_chan && (in_byte == "0" || in_byte == "1"));

  logic unused_bits;
  assign unused_bits = ^{sh[39:24+PH_W], sh[23:8+AMP_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pos <= '0; sh <= '0;
      armed <= 1'b0; sel_q <= 1'b0; ch_q <= 1'b0; have0 <= 1'b0;
      addr_q <= '0; a0 <= '0; d0 <= '0;
      wr_en <= 1'b0; wr_chan <= 1'b0; wr_addr <= '0; wr_freq <= '0;
      wr_phase <= '0; wr_amp <= '0; wr_dwell <= '0;
      syn_err <= 1'b0; pair_err <= 1'b0;
    end else begin
      wr_en <= 1'b0; syn_err <= 1'b0; pair_err <= 1'b0;
      if (in_valid) begin
        case (st)
          S_IDLE:
            if (is_t) begin
              st <= S_CMD; pos <= 5'd1;
            end else if (armed && hv) begin
              st <= S_REC; pos <= 5'd1; sh <= {sh[4*NIBS-5:0], nib};
            end else if (!is_term) begin
              syn_err <= 1'b1; armed <= 1'b0; st <= S_SKIP;
            end
          S_SKIP:
            if (is_term) st <= S_IDLE;
          default:
            if (!good) begin
              syn_err <= 1'b1; armed <= 1'b0;
              st <= is_term ? S_IDLE : S_SKIP;
            end else if (exp_term) begin
              st <= S_IDLE;
              if (in_cmd) begin
                armed <= 1'b1; ch_q <= sel_q; addr_q <= sh[15:0];
              end else begin
                armed    <= 1'b0;
                wr_en    <= 1'b1;
                wr_chan  <= ch_q;
                wr_addr  <= addr_q;
                wr_freq  <= sh[71:40];
                wr_phase <= sh[24 +: PH_W];
                wr_amp   <= sh[8 +: AMP_W];
                wr_dwell <= sh[7:0];
                if (!ch_q) begin
                  a0 <= addr_q; d0 <= sh[7:0]; have0 <= 1'b1;
                end else begin
                  pair_err <= have0 && (a0 != addr_q || d0 != sh[7:0]);
                  have0    <= 1'b0;
                end
              end
            end else begin
              pos <= pos + 5'd1;
              if (exp_hex) sh <= {sh[4*NIBS-5:0], nib};
              if (exp_chan) sel_q <= in_byte[0];
            end
        endcase
      end
    end
  end
endmodule

// File: rtl/prof_rec_parser_chk.sv
`timescale 1ns/1ps
module prof_rec_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        wr_en,
  input logic        wr_chan,
  input logic [15:0] wr_addr,
  input logic [31:0] wr_freq,
  input logic        syn_err,
  input logic        pair_err
);
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_addr) && $stable(wr_freq)));

  assert_no_write_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && syn_err));

  assert_pair_with_ch1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |-> (wr_en && wr_chan));

  assert_quiet_without_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!wr_en && !syn_err));
endmodule

bind prof_rec_parser prof_rec_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wr_en(wr_en),
  .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_freq(wr_freq),
  .syn_err(syn_err), .pair_err(pair_err)
);

// File: tb/sim_prof_rec_parser.sv
`timescale 1ns/1ps
module sim_prof_rec_parser;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic wr_en, wr_chan, syn_err, pair_err;
  logic [15:0] wr_addr;
  logic [31:0] wr_freq;
  logic [13:0] wr_phase;
  logic [9:0]  wr_amp;
  logic [7:0]  wr_dwell;

  always #2.5 clk = ~clk;

  prof_rec_parser u0 (.*);

  int n_chk = 0, n_fail = 0, n_wr = 0, n_err = 0, n_pair = 0;
  bit finished = 0;

  always @(negedge clk) if (rst_n) begin
    if (wr_en) n_wr++;
    if (syn_err) n_err++;
    if (pair_err) n_pair++;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0; in_byte = "x";
  endtask

  task automatic idle(int n);
    in_valid = 1'b0; in_byte = "q";
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] hexc(logic [3:0] n, bit uc);
    if (n < 10) return 8'("0" + n);
    return 8'((uc ? "A" : "a") + n - 10);
  endfunction

  task automatic send_hex(logic [31:0] v, int nd, bit uc);
    for (int i = nd - 1; i >= 0; i--) send(hexc(v[4*i +: 4], uc));
  endtask

  task automatic send_cmd(bit ch, logic [15:0] a, bit uc, logic [7:0] term);
    send(uc ? "T" : "t"); send(ch ? "1" : "0"); send(" ");
    send_hex(32'(a), 4, uc); send(term);
  endtask

  task automatic send_rec(logic [31:0] f, logic [15:0] p, logic [15:0] am,
                          logic [7:0] d, bit uc, logic [7:0] term);
    send_hex(f, 8, uc); send(",");
    send_hex(32'(p), 4, uc); send(",");
    send_hex(32'(am), 4, uc); send(",");
    send_hex(32'(d), 2, uc); send(term);
  endtask

  typedef struct packed {
    logic        ch;
    logic        uc;
    logic [15:0] addr;
    logic [31:0] freq;
    logic [15:0] ph;
    logic [15:0] amp;
    logic [7:0]  dw;
    logic        pair;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 16'h0000, 32'h12345678, 16'hffff, 16'hffff, 8'h01, 1'b0},
    '{1'b1, 1'b1, 16'h0000, 32'h9abcdef0, 16'hc123, 16'h0400, 8'h01, 1'b0},
    '{1'b0, 1'b1, 16'h3fff, 32'hffffffff, 16'h0000, 16'h03ff, 8'hff, 1'b0},
    '{1'b1, 1'b0, 16'h3fff, 32'h00000000, 16'h3fff, 16'hfc00, 8'hff, 1'b0},
    '{1'b0, 1'b1, 16'h1234, 32'ha5a5c3c3, 16'h4abc, 16'h8155, 8'h10, 1'b0},
    '{1'b1, 1'b0, 16'h1235, 32'h0f0f0f0f, 16'h1111, 16'h0222, 8'h10, 1'b1},
    '{1'b0, 1'b0, 16'h0042, 32'hdeadbeef, 16'h2000, 16'h0001, 8'h20, 1'b0},
    '{1'b1, 1'b1, 16'h0042, 32'hcafef00d, 16'h0001, 16'h0200, 8'h21, 1'b1}
  };

  int w0, e0, p0;
  task automatic snap(); w0 = n_wr; e0 = n_err; p0 = n_pair; endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_en", 64'(wr_en), 0);
    chk("R1 syn_err", 64'(syn_err), 0);
    chk("R1 pair_err", 64'(pair_err), 0);
    chk("R1 fields", {wr_addr, wr_freq, wr_dwell, 8'(wr_amp)}, 0);

    // R9 point line with no selector after reset
    snap();
    send_rec(32'h11111111, 16'h1, 16'h1, 8'h1, 0, 8'h0d); settle();
    chk("R9 err no selector", 64'(n_err - e0), 1);
    chk("R9 no write", 64'(n_wr - w0), 0);

    // R2 R3 R4 R5 R10: table walk
    foreach (VECS[k]) begin
      snap();
      send_cmd(VECS[k].ch, VECS[k].addr, VECS[k].uc, k[0] ? 8'h0a : 8'h0d);
      send_rec(VECS[k].freq, VECS[k].ph, VECS[k].amp, VECS[k].dw, VECS[k].uc,
               k[1] ? 8'h0a : 8'h0d);
      settle();
      chk("R3 one write", 64'(n_wr - w0), 1);
      chk("R8 no error", 64'(n_err - e0), 0);
      chk("R2 chan/addr", {wr_chan, wr_addr}, {VECS[k].ch, VECS[k].addr});
      chk("R5 freq", 64'(wr_freq), 64'(VECS[k].freq));
      chk("R4 phase", 64'(wr_phase), 64'(VECS[k].ph & 16'h3fff));
      chk("R4 amp", 64'(wr_amp), 64'(VECS[k].amp & 16'h03ff));
      chk("R3 dwell", 64'(wr_dwell), 64'(VECS[k].dw));
      chk("R10 pair", 64'(n_pair - p0), 64'(VECS[k].pair));
    end

    // R3 strobe timing: high right after the line end, low one cycle later
    send_cmd(0, 16'h0777, 0, 8'h0d);
    send_hex(32'h01020304, 8, 0); send(",");
    send_hex(32'h1, 4, 0); send(",");
    send_hex(32'h2, 4, 0); send(",");
    send_hex(32'h3, 2, 0); send(8'h0d);
    chk("R3 strobe cycle", 64'(wr_en), 1);
    @(posedge clk); #1;
    chk("R3 strobe ends", 64'(wr_en), 0);

    // R9 second point line without a new selector
    snap();
    send_rec(32'h5, 16'h5, 16'h5, 8'h5, 0, 8'h0d); settle();
    chk("R9 reuse rejected", 64'(n_err - e0), 1);
    chk("R9 reuse no write", 64'(n_wr - w0), 0);

    // R6 wrong delimiter
    snap();
    send_cmd(0, 16'h0100, 0, 8'h0d);
    send_hex(32'h12345678, 8, 0); send(";");
    send_hex(32'h1, 4, 0); send(","); send_hex(32'h2, 4, 0); send(",");
    send_hex(32'h3, 2, 0); send(8'h0d); settle();
    chk("R6 comma err", 64'(n_err - e0), 1);
    chk("R6 comma no write", 64'(n_wr - w0), 0);

    // R7 short line
    snap();
    send_cmd(0, 16'h0101, 0, 8'h0d);
    send_hex(32'h12345678, 8, 0); send(",");
    send_hex(32'h1, 4, 0); send(","); send_hex(32'h2, 4, 0); send(",");
    send_hex(32'h3, 1, 0); send(8'h0a); settle();
    chk("R7 short err", 64'(n_err - e0), 1);
    chk("R7 short no write", 64'(n_wr - w0), 0);

    // R7 long line
    snap();
    send_cmd(0, 16'h0102, 0, 8'h0d);
    send_rec(32'h1, 16'h1, 16'h1, 8'h1, 0, "7"); send(8'h0d); settle();
    chk("R7 long err", 64'(n_err - e0), 1);
    chk("R7 long no write", 64'(n_wr - w0), 0);

    // R8 R12 non-hex digit, rest of line skipped
    snap();
    send_cmd(0, 16'h0103, 0, 8'h0d);
    send("1"); send("g"); send_hex(32'h345678, 6, 0); send(",");
    send_hex(32'h1, 4, 0); send(","); send_hex(32'h2, 4, 0); send(",");
    send_hex(32'h3, 2, 0); send(8'h0d); settle();
    chk("R12 single err", 64'(n_err - e0), 1);
    chk("R8 nonhex no write", 64'(n_wr - w0), 0);

    // R2 bad channel digit, then the point line is not armed either
    snap();
    send("t"); send("2"); send(" "); send_hex(32'h1, 4, 0); send(8'h0d);
    send_rec(32'h1, 16'h1, 16'h1, 8'h1, 0, 8'h0d); settle();
    chk("R2 bad channel", 64'(n_err - e0), 2);
    chk("R2 bad channel no write", 64'(n_wr - w0), 0);

    // R11 empty lines and gaps with in_valid low inside a line
    snap();
    send(8'h0d); send(8'h0a); send(8'h0a);
    send_cmd(1, 16'h0abc, 0, 8'h0d);
    send_hex(32'h89abcdef, 8, 0); idle(3);
    send(","); send_hex(32'h0042, 4, 0); send(",");
    idle(2);
    send_hex(32'h0133, 4, 0); send(","); send_hex(32'h7e, 2, 0); send(8'h0d);
    settle();
    chk("R11 no err", 64'(n_err - e0), 0);
    chk("R11 one write", 64'(n_wr - w0), 1);
    chk("R11 fields", {wr_addr, wr_freq, 6'(0), wr_dwell}, {16'h0abc, 32'h89abcdef, 6'(0), 8'h7e});

    // R10 channel-1 write with no channel-0 before it: no pair error
    snap();
    send_cmd(1, 16'h0999, 1, 8'h0d);
    send_rec(32'h1, 16'h2, 16'h3, 8'h44, 1, 8'h0d); settle();
    chk("R10 lone ch1", 64'(n_pair - p0), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule